// File: doc/BRIEF.md
# CAN Bit-Timing Quantum Generator

This block divides the system clock into time quanta and lays every CAN bit out as one synchronisation quantum, a first phase segment and a second phase segment. At the border between the two phase segments it samples the received line and emits a sample strobe together with the sampled level. When a new bit begins it emits a bit-start strobe. Framing, bit stuffing and CRC belong to the logic that consumes these strobes.

The timing is set through a small write port that has two registers. The timing register packs the low prescaler bits, the jump width and both segment lengths. The extension register supplies the upper prescaler bits. Every field holds its value minus one. The registers accept writes only while the node is held in initialisation with the configuration-change enable also set. Clearing the initialisation input releases the node, and the block then free-runs. A recessive-to-dominant edge on the line while the bus is idle causes a hard synchronisation, which restarts the bit. An edge inside a running bit causes a resynchronisation: the first phase segment is stretched, or the second is shortened, by at most the jump width.

The outputs are single-cycle strobes that carry no ready input. The bus cannot be stalled, so the consumer must take each strobe in the cycle it appears, and back-pressure does not exist at this edge.

Top module: `cbt_bit_timer`

## Requirements
- R1: After reset the timing register holds prescaler field 1, jump-width field 0, first-segment field 3 and second-segment field 2. The extension register holds 0. Once the node is released, a bit therefore lasts 16 clocks and the sample strobe comes 10 clocks after bit start.
- R2: The quantum tick repeats every P+1 clocks. P is the 10-bit prescaler value: extension bits 3:0 form bits 9:6 and timing register bits 5:0 form bits 5:0.
- R3: Successive bit-start strobes in a bit free of edges are Q*(1+L1+L2) clocks apart, where Q=P+1, L1 is timing register bits 11:8 plus one and L2 is bits 14:12 plus one. The sample strobe comes Q*(1+L1) clocks after bit start and never in the same cycle as bit start. The sampled bit equals the line level at that point.
- R4: A write with address 0 loads the timing register and a write with address 1 loads the extension register. Either write takes effect only while init_bit and cfg_en_bit are both high. Any other write is ignored.
- R5: While init_bit is high, neither sample strobe nor bit-start strobe is produced.
- R6: A falling edge on rx_in while the bus is idle restarts the bit: bit_start rises two clocks after rx_in falls.
- R7: The bus is idle from release until the first hard synchronisation. It becomes idle again after IDLE_BITS consecutive recessive samples. A hard synchronisation clears the idle state.
- R8: A falling edge processed while the first phase segment is in its k-th quantum (k from 0) lengthens that segment by min(k+1, J) quanta, where J is timing register bits 7:6 plus one.
- R9: A falling edge processed in the k-th quantum of the second phase segment behaves in one of two ways. If L2-k <= J, the bit restarts as in R6. Otherwise the segment is shortened by J quanta.
- R10: At most one synchronisation acts per bit, and a hard synchronisation counts as that one. An edge during the synchronisation quantum changes nothing.
- R11: A first-segment field of 0 is treated as 1, so the first segment is never shorter than 2 quanta.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the timing register, 1 selects the extension register |
| wr_data | input | 16 | Write data |
| init_bit | input | 1 | Holds the node in initialisation while high |
| cfg_en_bit | input | 1 | Configuration-change enable |
| rx_in | input | 1 | Received bus line, 1 = recessive |
| tq_tick | output | 1 | One-clock pulse at the end of each quantum |
| sample_stb | output | 1 | One-clock pulse at the sample point |
| sample_bit | output | 1 | Line level captured at the last sample point |
| bit_start | output | 1 | One-clock pulse when a bit begins |

## Verification
The bench builds the block with IDLE_BITS set to 3. Re-entry into the idle state is therefore reached after three recessive bits, not eleven, which brings the hard-sync-after-idle case into a short run. The reset register values are left at their defaults, so the first checks see the 16-clock bit without any write. The register port is driven with settings that reach both ends of the segment ranges, a prescaler that needs the extension bits, and a setup with a four-clock quantum and a jump width of two. With that setup, edges placed on exact quanta hit the stretch cap and both branches of the shortening rule.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int REG_W     = 16;
  localparam int BRP_LO_W  = 6;
  localparam int BRP_HI_W  = 4;
  localparam int BRP_W     = BRP_LO_W + BRP_HI_W;
  localparam int SJW_W     = 2;
  localparam int TS1_W     = 4;
  localparam int TS2_W     = 3;
  localparam int SJW_Q_W   = SJW_W + 1;
  localparam int LEN1_W    = TS1_W + 1;
  localparam int LEN2_W    = TS2_W + 1;
  localparam int QC_W      = LEN1_W;

  localparam logic ADDR_TIMING = 1'b0;
  localparam logic ADDR_EXT    = 1'b1;

  typedef struct packed {
    logic             spare;
    logic [TS2_W-1:0] tseg2;
    logic [TS1_W-1:0] tseg1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_LO_W-1:0] brp_lo;
  } timing_reg_t;

  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_cfg_regs.sv
module cbt_cfg_regs
  import cbt_pkg::*;
#(
  parameter logic [REG_W-1:0]    TIMING_RST = 16'h2301,
  parameter logic [BRP_HI_W-1:0] EXT_RST    = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  wr_addr,
  input  logic [REG_W-1:0]      wr_data,
  input  logic                  init_bit,
  input  logic                  cfg_en_bit,
  output timing_reg_t           timing_q,
  output logic [BRP_HI_W-1:0]   ext_q,
  output logic [BRP_W-1:0]      presc,
  output logic [SJW_Q_W-1:0]    jump_q,
  output logic [LEN1_W-1:0]     len1,
  output logic [LEN2_W-1:0]     len2
);
  logic wr_ok;
  assign wr_ok = wr_en & init_bit & cfg_en_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_q <= timing_reg_t'(TIMING_RST);
      ext_q    <= EXT_RST;
    end else if (wr_ok) begin
      if (wr_addr == ADDR_TIMING) timing_q <= timing_reg_t'(wr_data);
      else                        ext_q    <= wr_data[BRP_HI_W-1:0];
    end
  end

  // stored fields are value-minus-one; segment one is floored at 2 quanta
  assign presc  = {ext_q, timing_q.brp_lo};
  assign jump_q = {1'b0, timing_q.sjw} + SJW_Q_W'(1);
  assign len1   = (timing_q.tseg1 == '0) ? LEN1_W'(2)
                                         : {1'b0, timing_q.tseg1} + LEN1_W'(1);
  assign len2   = {1'b0, timing_q.tseg2} + LEN2_W'(1);
endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler
  import cbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [BRP_W-1:0] presc,
  output logic             tick
);
  logic [BRP_W-1:0] cnt;

  assign tick = run & (cnt == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (!run || clr)          cnt <= '0;
    else if (cnt >= presc)         cnt <= '0;
    else                           cnt <= cnt + BRP_W'(1);
  end
endmodule

// File: rtl/cbt_rx_edge.sv
module cbt_rx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_in,
  output logic rx_lvl,
  output logic fall
);
  logic rx_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_lvl  <= 1'b1;
      rx_prev <= 1'b1;
    end else begin
      rx_lvl  <= rx_in;
      rx_prev <= rx_lvl;
    end
  end

  assign fall = rx_prev & ~rx_lvl;
endmodule

// File: rtl/cbt_bit_fsm.sv
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int IDLE_BITS = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               tick,
  input  logic               fall,
  input  logic               rx_lvl,
  input  logic [SJW_Q_W-1:0] jump_q,
  input  logic [LEN1_W-1:0]  len1,
  input  logic [LEN2_W-1:0]  len2,
  output logic               presc_clr,
  output logic               sample_stb,
  output logic               sample_bit,
  output logic               bit_start,
  output logic               idle
);
  localparam int IDLE_W = $clog2(IDLE_BITS + 1);

  seg_e               seg;
  logic [QC_W-1:0]    qcnt;
  logic [SJW_Q_W-1:0] stretch;
  logic               shrink;
  logic               synced;
  logic [IDLE_W-1:0]  rec_cnt;

  logic              hard, resync, cut;
  logic [QC_W-1:0]   len1_eff, len2_eff, late, remain;
  logic [SJW_Q_W-1:0] stretch_n;

  assign len1_eff  = QC_W'(len1) + QC_W'(stretch);
  assign len2_eff  = shrink ? QC_W'(len2) - QC_W'(jump_q) : QC_W'(len2);
  assign late      = qcnt + QC_W'(1);
  assign stretch_n = (late < QC_W'(jump_q)) ? late[SJW_Q_W-1:0] : jump_q;
  assign remain    = QC_W'(len2) - qcnt;
  assign cut       = (remain <= QC_W'(jump_q));

  assign hard      = run & fall & idle;
  assign resync    = run & fall & ~idle & ~synced;
  assign presc_clr = hard | (resync & (seg == SEG_PH2) & cut);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg <= SEG_SYNC; qcnt <= '0; stretch <= '0; shrink <= 1'b0;
      synced <= 1'b0; idle <= 1'b1; rec_cnt <= '0;
      sample_stb <= 1'b0; sample_bit <= 1'b1; bit_start <= 1'b0;
    end else if (!run) begin
      seg <= SEG_SYNC; qcnt <= '0; stretch <= '0; shrink <= 1'b0;
      synced <= 1'b0; idle <= 1'b1; rec_cnt <= '0;
      sample_stb <= 1'b0; bit_start <= 1'b0;
    end else begin
      sample_stb <= 1'b0;
      bit_start  <= 1'b0;
      if (presc_clr) begin
        // restart the bit at the edge
        seg <= SEG_SYNC; qcnt <= '0; stretch <= '0; shrink <= 1'b0;
        synced    <= 1'b1;
        bit_start <= 1'b1;
        if (hard) begin
          idle    <= 1'b0;
          rec_cnt <= '0;
        end
      end else begin
        if (resync && seg == SEG_PH1) begin
          stretch <= stretch_n;
          synced  <= 1'b1;
        end
        if (resync && seg == SEG_PH2) begin
          shrink <= 1'b1;
          synced <= 1'b1;
        end
        if (tick) begin
          unique case (seg)
            SEG_SYNC: begin
              seg  <= SEG_PH1;
              qcnt <= '0;
            end
            SEG_PH1: begin
              if (qcnt >= len1_eff - QC_W'(1)) begin
                seg        <= SEG_PH2;
                qcnt       <= '0;
                sample_stb <= 1'b1;
                sample_bit <= rx_lvl;
                if (rx_lvl) begin
                  if (int'(rec_cnt) >= IDLE_BITS - 1) idle <= 1'b1;
                  else rec_cnt <= rec_cnt + IDLE_W'(1);
                end else begin
                  rec_cnt <= '0;
                end
              end else begin
                qcnt <= qcnt + QC_W'(1);
              end
            end
            SEG_PH2: begin
              if (qcnt >= len2_eff - QC_W'(1)) begin
                seg       <= SEG_SYNC;
                qcnt      <= '0;
                stretch   <= '0;
                shrink    <= 1'b0;
                synced    <= 1'b0;
                bit_start <= 1'b1;
              end else begin
                qcnt <= qcnt + QC_W'(1);
              end
            end
            default: seg <= SEG_SYNC;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cbt_bit_timer.sv
module cbt_bit_timer
  import cbt_pkg::*;
#(
  parameter int                  IDLE_BITS  = 11,
  parameter logic [REG_W-1:0]    TIMING_RST = 16'h2301,
  parameter logic [BRP_HI_W-1:0] EXT_RST    = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             init_bit,
  input  logic             cfg_en_bit,
  input  logic             rx_in,
  output logic             tq_tick,
  output logic             sample_stb,
  output logic             sample_bit,
  output logic             bit_start
);
  timing_reg_t          timing_val;
  logic [BRP_HI_W-1:0]  ext_val;
  logic [BRP_W-1:0]     presc;
  logic [SJW_Q_W-1:0]   jump_q;
  logic [LEN1_W-1:0]    len1;
  logic [LEN2_W-1:0]    len2;
  logic                 run, presc_clr, rx_lvl, fall_w, idle_w;

  assign run = ~init_bit;

  cbt_cfg_regs #(.TIMING_RST(TIMING_RST), .EXT_RST(EXT_RST)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .init_bit(init_bit), .cfg_en_bit(cfg_en_bit),
    .timing_q(timing_val), .ext_q(ext_val), .presc(presc),
    .jump_q(jump_q), .len1(len1), .len2(len2)
  );

  cbt_prescaler u_presc (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(presc_clr),
    .presc(presc), .tick(tq_tick)
  );

  cbt_rx_edge u_edge (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_lvl(rx_lvl), .fall(fall_w)
  );

  cbt_bit_fsm #(.IDLE_BITS(IDLE_BITS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run(run), .tick(tq_tick), .fall(fall_w),
    .rx_lvl(rx_lvl), .jump_q(jump_q), .len1(len1), .len2(len2),
    .presc_clr(presc_clr), .sample_stb(sample_stb), .sample_bit(sample_bit),
    .bit_start(bit_start), .idle(idle_w)
  );
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        init_bit,
  input logic        cfg_en_bit,
  input logic [15:0] timing_raw,
  input logic [3:0]  ext_raw,
  input logic        idle,
  input logic        fall,
  input logic        sample_stb,
  input logic        bit_start
);
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sample_stb && bit_start)); // R3
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(init_bit && cfg_en_bit) |=> ($stable(timing_raw) && $stable(ext_raw))); // R4
  AST_INIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    init_bit |=> (!sample_stb && !bit_start)); // R5
  AST_HSYNC_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_bit && idle && fall) |=> bit_start); // R6
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_bit && idle && fall) |=> !idle); // R7
endmodule

bind cbt_bit_timer cbt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .init_bit(init_bit), .cfg_en_bit(cfg_en_bit),
  .timing_raw(timing_val), .ext_raw(ext_val), .idle(idle_w), .fall(fall_w),
  .sample_stb(sample_stb), .bit_start(bit_start)
);

// File: tb/cbt_bit_timer_bench.sv
module cbt_bit_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_addr = 1'b0;
  logic [15:0] wr_data = '0;
  logic        init_bit = 1'b1;
  logic        cfg_en_bit = 1'b0;
  logic        rx_in = 1'b1;
  logic        tq_tick, sample_stb, sample_bit, bit_start;
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cbt_bit_timer #(.IDLE_BITS(3)) u_cbt_bit_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .init_bit(init_bit), .cfg_en_bit(cfg_en_bit),
    .rx_in(rx_in), .tq_tick(tq_tick), .sample_stb(sample_stb),
    .sample_bit(sample_bit), .bit_start(bit_start)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_bs(output int at);
    int g = 0;
    do begin @(negedge clk); g++; end while (!bit_start && g < 5000);
    if (!bit_start) check("timeout waiting bit_start", 0, 1);
    at = cyc;
  endtask

  task automatic wait_ss(output int at);
    int g = 0;
    do begin @(negedge clk); g++; end while (!sample_stb && g < 5000);
    if (!sample_stb) check("timeout waiting sample_stb", 0, 1);
    at = cyc;
  endtask

  task automatic at_cyc(input int x);
    while (cyc < x) @(negedge clk);
  endtask

  task automatic configure(input logic [15:0] tim, input logic [3:0] ext);
    @(negedge clk);
    rx_in = 1'b1; init_bit = 1'b1; cfg_en_bit = 1'b1;
    @(negedge clk); wr_en = 1'b1; wr_addr = 1'b0; wr_data = tim;
    @(negedge clk); wr_addr = 1'b1; wr_data = {12'h0, ext};
    @(negedge clk); wr_en = 1'b0; cfg_en_bit = 1'b0;
    @(negedge clk); init_bit = 1'b0;
  endtask

  // measure period between two bit starts and the sample offset inside the bit
  task automatic measure(input string req, input int per, input int off);
    int a, b, s;
    wait_bs(a);
    wait_ss(s);
    wait_bs(b);
    check({req, " bit period"}, b - a, per);
    check({req, " sample offset"}, s - a, off);
  endtask

  // hard sync on an idle bus, leaves a bit that is not idle and not synced next
  task automatic hsync(output int h);
    int b, d, s;
    wait_bs(b);
    at_cyc(b + 5);
    d = cyc; rx_in = 1'b0;
    wait_bs(h);
    check("R6 hard sync latency", h - d, 2);
    wait_ss(s);
    check("R3 dominant sample value", int'(sample_bit), 0);
    at_cyc(h + 30);
    rx_in = 1'b1;
  endtask

  task automatic t_reset;
    int seen = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (30) begin
      @(negedge clk);
      if (sample_stb || bit_start) seen++;
    end
    check("R5 strobes while held in init", seen, 0);
    init_bit = 1'b0;
    measure("R1 default", 16, 10);
  endtask

  task automatic t_patterns;
    int a, b, s;
    configure(16'h1202, 4'h1);
    @(negedge clk); while (!tq_tick) @(negedge clk);
    a = cyc;
    @(negedge clk); while (!tq_tick) @(negedge clk);
    check("R2 quantum spacing with extension bits", cyc - a, 67);
    measure("R3 wide prescaler", 402, 268);
    configure(16'h7F00, 4'h0);
    measure("R3 maximum segments", 25, 17);
    wait_ss(s);
    check("R3 recessive sample value", int'(sample_bit), 1);
  endtask

  task automatic t_lock;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 1'b0; wr_data = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    measure("R4 write while running ignored", 25, 17);
    init_bit = 1'b1; cfg_en_bit = 1'b0;
    @(negedge clk); wr_en = 1'b1; wr_data = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk); init_bit = 1'b0;
    measure("R4 write without enable ignored", 25, 17);
  endtask

  task automatic t_tseg1_floor;
    configure(16'h0000, 4'h0);
    measure("R11 zero first-segment field", 4, 3);
  endtask

  task automatic t_seg1;
    int h, nb, nx;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    at_cyc(nb + 3); rx_in = 1'b0;
    wait_bs(nx);
    check("R8 stretch by one quantum", nx - nb, 44);
    rx_in = 1'b1;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    at_cyc(nb + 11); rx_in = 1'b0;
    wait_bs(nx);
    check("R8 stretch capped at jump width", nx - nb, 48);
    rx_in = 1'b1;
  endtask

  task automatic t_seg2;
    int h, nb, nx;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    at_cyc(nb + 23); rx_in = 1'b0;
    wait_bs(nx);
    check("R9 shorten by jump width", nx - nb, 32);
    rx_in = 1'b1;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    at_cyc(nb + 31); rx_in = 1'b0;
    wait_bs(nx);
    check("R9 restart at edge inside jump width", nx - nb, 33);
    rx_in = 1'b1;
  endtask

  task automatic t_once;
    int h, nb, nx;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    at_cyc(nb + 3);  rx_in = 1'b0;
    at_cyc(nb + 6);  rx_in = 1'b1;
    at_cyc(nb + 11); rx_in = 1'b0;
    wait_bs(nx);
    check("R10 second edge in a bit ignored", nx - nb, 44);
    rx_in = 1'b1;
    configure(16'h3443, 4'h0);
    hsync(h);
    wait_bs(nb);
    rx_in = 1'b0;
    wait_bs(nx);
    check("R10 edge in sync quantum ignored", nx - nb, 40);
    rx_in = 1'b1;
  endtask

  task automatic t_idle;
    int h, nb, nx;
    configure(16'h3443, 4'h0);
    hsync(h);
    repeat (4) wait_bs(nb);
    check("R7 bit grid before idle re-entry", nb - h, 160);
    at_cyc(nb + 3); rx_in = 1'b0;
    wait_bs(nx);
    check("R7 hard sync after recessive run", nx - nb, 5);
    rx_in = 1'b1;
  endtask

  initial begin
    t_reset;
    t_patterns;
    t_lock;
    t_tseg1_floor;
    t_seg1;
    t_seg2;
    t_once;
    t_idle;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 200000);
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule